// File: doc/BRIEF.md
# Flying Capacitor Leg Redundant State Selector

This block drives the gates of a three-level flying capacitor converter, one leg per phase. Each leg has an outer and an inner transistor. For every phase, a modulator asks for an output level of low, middle or high, and the block turns that request into the two gate commands. The low and high levels each have a single switch pattern. The middle level has two patterns that give the same pole voltage. One pattern pushes phase current into the flying capacitor and the other pulls it out. Choosing between them is how the capacitor voltage is held at half the DC-link voltage.

The block makes this choice once per sampling period, when the period-start strobe is high. It compares each phase's capacitor voltage with half the DC-link voltage and takes the sign of that phase's current into account. The choice is then held until the next strobe, so each phase uses only one middle pattern per period. This keeps the number of commutations down. When a phase's choice differs from the one it held in the previous period, the block raises a one-cycle flag for that phase. A downstream pattern stage can use this flag to reorder its transitions. Dead time and the vector modulator are handled outside this block.

All gate outputs and flags are registered. The gates for the level requested at a clock edge appear in the cycle after that edge.

Top module: `fc_redundant_selector`

## Requirements
- R1: A requested level code of 2'b00 gives both gates off in the cycle after the edge where it is sampled.
- R2: A requested level code of 2'b10 gives both gates on in the cycle after the edge where it is sampled.
- R3: A requested level code of 2'b01 gives exactly one gate on in the cycle after the edge where it is sampled. The phase's held state decides which one:
  - In state A, the outer gate is on and the inner gate is off.
  - In state B, the outer gate is off and the inner gate is on.
- R4: At a strobe edge, the new state of a phase is found as follows:
  - The capacitor counts as below its reference when twice its voltage is strictly less than the DC-link voltage. Equality counts as not below.
  - The phase takes state A when "below its reference" differs from "current negative" (`cur_neg` = 1).
  - Otherwise it takes state B.
- R5: A phase's state changes only at edges where `period_start` is high. Changes of capacitor voltage, DC-link voltage or current sign between strobes have no effect on the middle-level gates.
- R6: At a strobe edge, a middle-level request sampled at that same edge already uses the newly chosen state.
- R7: A phase's `red_flip` is high for exactly the cycle after a strobe edge at which its new state differs from its previous state. It is low at all other times.
- R8: While reset is low, and until the first edge after reset is released, all gates and flags are low. The held state of every phase starts as A.
- R9: The unused level code 2'b11 gives both gates off.
- R10: Each phase's gates, state and flag depend only on that phase's own level, current sign and capacitor voltage, plus the shared DC-link voltage and strobe.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| period_start | input | 1 | Sampling period start strobe; the state choice is taken at edges where it is high |
| level_req | input | 2*NPH | Requested level per phase, 2 bits each, with phase i at bits [2i+1:2i]: 00 low, 01 middle, 10 high, 11 unused |
| cur_neg | input | NPH | Per phase, 1 when the phase current is negative |
| vfc | input | NPH*VW | Flying capacitor voltage per phase, unsigned, with phase i at bits [VW*i+VW-1:VW*i] |
| vdc | input | VW | DC-link voltage, unsigned |
| gate_outer | output | NPH | Outer transistor gate command per phase |
| gate_inner | output | NPH | Inner transistor gate command per phase |
| red_flip | output | NPH | One-cycle flag: this phase's state changed at the last strobe |

## Verification
The hardest case to reach is one where the held state must resist inputs that would select the other state. The current sign or capacitor voltage of a phase has to reverse between strobes while that phase sits at the middle level, and the gates must not follow. The stimulus makes this happen by holding the middle level across several non-strobe cycles and sweeping the capacitor voltage back and forth across half of the DC-link voltage. It also toggles the current sign. A later strobe then has to pick up the reversal and raise the flip flag. The exact-equality boundary of the comparison is also driven on purpose, with an even DC-link voltage.

// File: rtl/fcs_pkg.sv
package fcs_pkg;

    // Which of the two middle-level switch patterns a phase uses.
    typedef enum logic {
        ST_A = 1'b0,   // outer on, inner off
        ST_B = 1'b1    // outer off, inner on
    } red_e;

    // Encoding of a requested output level.
    typedef enum logic [1:0] {
        LV_LOW  = 2'd0,
        LV_MID  = 2'd1,
        LV_HIGH = 2'd2,
        LV_BAD  = 2'd3
    } lvl_e;

    typedef struct packed {
        logic outer;
        logic inner;
    } gate_t;

endpackage

// File: rtl/fcs_choice.sv
module fcs_choice
    import fcs_pkg::*;
#(
    parameter int VW = 12
) (
    input  logic [VW-1:0] vfc,
    input  logic [VW-1:0] vdc,
    input  logic          cur_neg,
    output red_e          pick
);
    localparam int CW = VW + 1;

    logic [CW-1:0] twice_fc;
    logic [CW-1:0] link_ext;
    logic          below;

    // Comparing twice the capacitor voltage against the link voltage
    // avoids losing the odd bit that halving the link would drop.
    always_comb begin
        twice_fc = {vfc, 1'b0};
        link_ext = {1'b0, vdc};
        below    = (twice_fc < link_ext);
        pick     = (below ^ cur_neg) ? ST_A : ST_B;
    end
endmodule

// File: rtl/fcs_gate_map.sv
module fcs_gate_map
    import fcs_pkg::*;
(
    input  logic [1:0] lvl,
    input  red_e       st,
    output gate_t      g
);
    always_comb begin
        unique case (lvl_e'(lvl))
            LV_LOW:  g = '{outer: 1'b0, inner: 1'b0};
            LV_MID:  g = (st == ST_A) ? gate_t'{outer: 1'b1, inner: 1'b0}
                                      : gate_t'{outer: 1'b0, inner: 1'b1};
            LV_HIGH: g = '{outer: 1'b1, inner: 1'b1};
            default: g = '{outer: 1'b0, inner: 1'b0};
        endcase
    end
endmodule

// File: rtl/fc_redundant_selector.sv
module fc_redundant_selector
    import fcs_pkg::*;
#(
    parameter int NPH = 3,
    parameter int VW  = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              period_start,
    input  logic [2*NPH-1:0]  level_req,
    input  logic [NPH-1:0]    cur_neg,
    input  logic [NPH*VW-1:0] vfc,
    input  logic [VW-1:0]     vdc,
    output logic [NPH-1:0]    gate_outer,
    output logic [NPH-1:0]    gate_inner,
    output logic [NPH-1:0]    red_flip
);
    localparam int LW = 2;

    typedef struct packed {
        logic [NPH-1:0] choice;
        logic [NPH-1:0] outer;
        logic [NPH-1:0] inner;
        logic [NPH-1:0] flip;
    } state_t;

    state_t state_d, state_q;

    red_e  pick [NPH];
    red_e  eff  [NPH];
    gate_t gm   [NPH];
    logic [NPH-1:0] choice_q;

    assign choice_q = state_q.choice;

    for (genvar i = 0; i < NPH; i++) begin : g_phase
        fcs_choice #(.VW(VW)) u_choice (
            .vfc     (vfc[VW*i +: VW]),
            .vdc     (vdc),
            .cur_neg (cur_neg[i]),
            .pick    (pick[i])
        );

        // At a strobe the new choice governs this edge's request.
        assign eff[i] = period_start ? pick[i] : red_e'(state_q.choice[i]);

        fcs_gate_map u_map (
            .lvl (level_req[LW*i +: LW]),
            .st  (eff[i]),
            .g   (gm[i])
        );
    end

    always_comb begin
        state_d = state_q;
        for (int i = 0; i < NPH; i++) begin
            state_d.choice[i] = eff[i];
            state_d.outer[i]  = gm[i].outer;
            state_d.inner[i]  = gm[i].inner;
            state_d.flip[i]   = period_start && (pick[i] != red_e'(state_q.choice[i]));
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= '0;
        end else begin
            state_q <= state_d;
        end
    end

    assign gate_outer = state_q.outer;
    assign gate_inner = state_q.inner;
    assign red_flip   = state_q.flip;

endmodule

// File: rtl/fcs_checker.sv
module fcs_checker #(
    parameter int NPH = 3
) (
    input logic             clk,
    input logic             rst_n,
    input logic             period_start,
    input logic [2*NPH-1:0] level_req,
    input logic [NPH-1:0]   gate_outer,
    input logic [NPH-1:0]   gate_inner,
    input logic [NPH-1:0]   red_flip,
    input logic [NPH-1:0]   choice_q
);
    for (genvar i = 0; i < NPH; i++) begin : g_chk
        p_low_off_r1: assert property (@(posedge clk) disable iff (!rst_n)
            level_req[2*i +: 2] == 2'b00 |=> !gate_outer[i] && !gate_inner[i]);

        p_high_on_r2: assert property (@(posedge clk) disable iff (!rst_n)
            level_req[2*i +: 2] == 2'b10 |=> gate_outer[i] && gate_inner[i]);

        p_mid_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
            level_req[2*i +: 2] == 2'b01 |=> $countones({gate_outer[i], gate_inner[i]}) == 1);

        p_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
            !period_start |=> $stable(choice_q[i]));

        p_new_state_r6: assert property (@(posedge clk) disable iff (!rst_n)
            period_start && level_req[2*i +: 2] == 2'b01 |=> gate_outer[i] == !choice_q[i]);

        p_flip_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
            !period_start |=> !red_flip[i]);

        p_bad_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
            level_req[2*i +: 2] == 2'b11 |=> !gate_outer[i] && !gate_inner[i]);
    end
endmodule

bind fc_redundant_selector fcs_checker #(.NPH(NPH)) u_fcs_checker (
    .clk          (clk),
    .rst_n        (rst_n),
    .period_start (period_start),
    .level_req    (level_req),
    .gate_outer   (gate_outer),
    .gate_inner   (gate_inner),
    .red_flip     (red_flip),
    .choice_q     (choice_q)
);

// File: tb/fc_redundant_selector_bench.sv
`timescale 1ns/1ps
module fc_redundant_selector_bench;
    localparam int NPH = 3;
    localparam int VW  = 12;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              period_start = 1'b0;
    logic [2*NPH-1:0]  level_req = '0;
    logic [NPH-1:0]    cur_neg = '0;
    logic [NPH*VW-1:0] vfc = '0;
    logic [VW-1:0]     vdc = '0;
    logic [NPH-1:0]    gate_outer, gate_inner, red_flip;

    always #4 clk = ~clk;   // 125 MHz

    fc_redundant_selector #(.NPH(NPH), .VW(VW)) u_fc_redundant_selector (
        .clk(clk), .rst_n(rst_n), .period_start(period_start),
        .level_req(level_req), .cur_neg(cur_neg), .vfc(vfc), .vdc(vdc),
        .gate_outer(gate_outer), .gate_inner(gate_inner), .red_flip(red_flip)
    );

    int total = 0;
    int bad   = 0;
    bit done  = 0;

    // Behavioural reference: 0 means state A, 1 means state B.
    int m_state [NPH];
    int m_outer [NPH];
    int m_inner [NPH];
    int m_flip  [NPH];
    int m_lvl   [NPH];
    bit m_strobe;
    bit m_reset = 1;

    always @(posedge clk) begin
        m_reset  = !rst_n;
        m_strobe = period_start;
        for (int p = 0; p < NPH; p++) begin
            if (!rst_n) begin
                m_state[p] = 0; m_outer[p] = 0; m_inner[p] = 0; m_flip[p] = 0; m_lvl[p] = 0;
            end else begin
                int lv, vc, vd, want;
                bit is_below;
                lv = int'(level_req[2*p +: 2]);
                vc = int'(vfc[VW*p +: VW]);
                vd = int'(vdc);
                is_below = (2*vc < vd);
                want = (is_below != cur_neg[p]) ? 0 : 1;
                m_flip[p] = 0;
                if (period_start) begin
                    m_flip[p]  = (want != m_state[p]) ? 1 : 0;
                    m_state[p] = want;
                end
                m_lvl[p] = lv;
                case (lv)
                    0: begin m_outer[p] = 0; m_inner[p] = 0; end
                    1: begin m_outer[p] = (m_state[p] == 0); m_inner[p] = (m_state[p] == 1); end
                    2: begin m_outer[p] = 1; m_inner[p] = 1; end
                    default: begin m_outer[p] = 0; m_inner[p] = 0; end
                endcase
            end
        end
    end

    // Compare on every clock, away from the active edge.
    always @(negedge clk) begin
        if (!done) begin
            for (int p = 0; p < NPH; p++) begin
                string tg;
                if (m_reset) tg = "R8";
                else case (m_lvl[p])
                    0: tg = "R1";
                    2: tg = "R2";
                    3: tg = "R9";
                    default: tg = m_strobe ? "R4 R6" : "R3 R5";
                endcase
                total++;
                if (int'(gate_outer[p]) != m_outer[p] || int'(gate_inner[p]) != m_inner[p]) begin
                    bad++;
                    $display("FAIL %s phase %0d gates outer/inner=%0d/%0d expected %0d/%0d",
                             tg, p, gate_outer[p], gate_inner[p], m_outer[p], m_inner[p]);
                end
                total++;
                if (int'(red_flip[p]) != m_flip[p]) begin
                    bad++;
                    $display("FAIL %s phase %0d red_flip=%0d expected %0d",
                             m_reset ? "R8" : "R7", p, red_flip[p], m_flip[p]);
                end
            end
        end
    end

    task automatic set_phase(input int p, input int lv, input bit neg, input int vc);
        level_req[2*p +: 2] = lv[1:0];
        cur_neg[p]          = neg;
        vfc[VW*p +: VW]     = vc[VW-1:0];
    endtask

    task automatic step(input bit strobe);
        period_start = strobe;
        @(negedge clk);
    endtask

    initial begin
        vdc = 12'd2000;
        repeat (4) @(negedge clk);        // R8 reset state checked here
        rst_n = 1'b1;

        // R10: each phase gets a different condition at the same strobe.
        set_phase(0, 1, 1'b0, 900);       // below, positive -> A
        set_phase(1, 1, 1'b0, 1000);      // equal boundary, positive -> B (R4)
        set_phase(2, 1, 1'b1, 1100);      // above, negative -> A
        step(1);
        // R5: sweep capacitor voltage and current sign without a strobe.
        for (int k = 0; k < 6; k++) begin
            set_phase(0, 1, k[0], (k % 2 == 0) ? 1500 : 300);
            set_phase(1, 1, ~k[0], 600 + 200*k);
            set_phase(2, 1, k[1], 1999 - 300*k);
            step(0);
        end
        // R7: strobe that reverses phase 0 and 1, keeps phase 2.
        set_phase(0, 1, 1'b0, 1200);      // above, positive -> B (flip)
        set_phase(1, 1, 1'b1, 1000);      // equal, negative -> A (flip)
        set_phase(2, 1, 1'b1, 1100);      // A again, no flip
        step(1);
        step(0);
        // R1 R2 R9 with held states.
        set_phase(0, 0, 1'b0, 0);
        set_phase(1, 2, 1'b1, 0);
        set_phase(2, 3, 1'b0, 4095);
        step(0);
        step(1);
        // Odd link voltage boundary for R4.
        vdc = 12'd2001;
        set_phase(0, 1, 1'b0, 1000);      // 2000 < 2001 below -> A
        set_phase(1, 1, 1'b0, 1001);      // 2002 not below -> B
        set_phase(2, 1, 1'b1, 1000);      // below, negative -> B
        step(1);
        step(0);

        // Mixed stimulus with periodic strobes.
        for (int c = 0; c < 4000; c++) begin
            if (c % 16 == 0) vdc = VW'(1000 + ($urandom % 2000));
            for (int p = 0; p < NPH; p++) begin
                int half;
                half = int'(vdc) / 2;
                set_phase(p, int'($urandom % 4), 1'($urandom % 2),
                          half - 20 + int'($urandom % 41));
            end
            step((c % 8) == 7);
        end

        // Reset in mid-run, R8.
        rst_n = 1'b0;
        step(0);
        step(0);
        rst_n = 1'b1;
        step(0);

        done = 1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule